// File: doc/BRIEF.md
# Two-Thread Branch Direction and Target Predictor

This block sits beside instruction fetch in an in-order core that runs two hardware threads. Fetch presents a thread number and a PC. In the same cycle it gets back a taken/not-taken guess, a flag that says whether a target is known, the target address, and the bias mark of the table entry it used. The direction guess comes from a two-level adaptive scheme. Each thread shifts its own conditional-branch outcomes into a private history register. Both threads index one shared table of 2-bit saturating counters, and each entry also carries a static-bias mark. Targets come from a set-associative branch target buffer.

When a branch retires, the resolve port carries the thread, the PC, the branch kind (conditional or unconditional), the outcome and the true target. In that cycle the block rebuilds its own prediction for the branch from its current state and reports a penalty class: 13 for a wrong direction, 7 for a correct direction whose target was not available, and 0 otherwise. At the next clock edge it trains the history, the counter, the bias mark and the target buffer. Unconditional jumps are kept out of the history and out of the counters. They still use the target buffer.

The history width, address width, buffer geometry and bias run length are parameters. The full configuration uses 12 history bits, which gives a 13-bit index and 8192 entries, with 32 sets of 4 ways. The elaborated default keeps the table small with 10 history bits.

Top module: `bpu_2t`

## Requirements
- R1: After reset every counter is weakly not-taken (binary 01), every bias mark is 00, every history register is zero and the target buffer holds no valid entry. Any lookup therefore returns f_taken=0, f_bias=00 and f_tgt_valid=0.
- R2: The table index is {pc[HIST_W+2], hist[tid] XOR pc[HIST_W+1:2]}. An entry with bias 00 predicts taken exactly when bit 1 of its counter is set. A conditional resolve moves the counter one step toward the outcome and saturates at 00 and 11.
- R3: The counter table is shared by both threads, and each thread has a private history. A conditional resolve shifts the outcome (1 = taken) into bit 0 of that thread's history only.
- R4: An unconditional resolve (r_uncond=1) changes neither the history nor any counter or bias state.
- R5: The bias field is 00 = none, 01 = always-taken, 10 = never-taken. An entry gets the mark of the outcome direction after RUN_LEN (8) consecutive conditional outcomes in one direction, and any opposite outcome clears it. A marked entry predicts its fixed direction, and f_bias reports the mark of the entry used by the lookup.
- R6: The target buffer set is pc[SB+1:2], and the tag is the PC bits above the set index. A lookup hit gives f_tgt_valid=1 and the stored target. A taken resolve of either kind writes the target into the hitting way, or allocates a way on a miss. A not-taken resolve never allocates.
- R7: Allocation picks the lowest-numbered invalid way. If every way is valid, it picks the lowest-numbered way whose recently-used bit is clear. Each write sets the written way's bit. When that would set every bit in the set, only the written way's bit stays set.
- R8: r_penalty is 13 when a conditional branch's direction was mispredicted. Otherwise it is 7 when the branch was taken and the buffer missed or held a different target. Otherwise it is 0, and it is always 0 while r_valid is low.
- R9: A lookup and a resolve in the same cycle see the state from before that resolve. The update is visible to lookups from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| f_tid | input | 1 | Lookup thread number |
| f_pc | input | AW | Lookup PC |
| f_taken | output | 1 | Predicted direction (1 = taken) |
| f_bias | output | 2 | Bias mark of the entry used |
| f_tgt_valid | output | 1 | Target buffer hit |
| f_tgt | output | AW | Predicted target |
| r_valid | input | 1 | Resolve strobe |
| r_tid | input | 1 | Resolve thread number |
| r_pc | input | AW | Resolved branch PC |
| r_uncond | input | 1 | 1 = unconditional jump, 0 = conditional |
| r_taken | input | 1 | Actual outcome |
| r_target | input | AW | Actual target |
| r_penalty | output | 4 | Penalty class: 0, 7 or 13 |

## Verification
The bench builds the block with HIST_W=4, AW=16, BTB_SETS=4, BTB_WAYS=4 and RUN_LEN=8. With only four history bits, a run of taken branches saturates a thread's history within four resolves. That makes repeated hits on one counter entry, and so the always-taken mark, reachable in a dozen steps. Four sets of four ways let five branches in one set force an eviction whose victim depends on the recently-used bits. The 16-bit addresses keep the hand-computed index, set and tag values easy to follow.

// File: rtl/bpu_2t.sv
module bpu_2t #(
  parameter int HIST_W   = 10,
  parameter int AW       = 32,
  parameter int BTB_SETS = 32,
  parameter int BTB_WAYS = 4,
  parameter int RUN_LEN  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          f_tid,
  input  logic [AW-1:0] f_pc,
  output logic          f_taken,
  output logic [1:0]    f_bias,
  output logic          f_tgt_valid,
  output logic [AW-1:0] f_tgt,
  input  logic          r_valid,
  input  logic          r_tid,
  input  logic [AW-1:0] r_pc,
  input  logic          r_uncond,
  input  logic          r_taken,
  input  logic [AW-1:0] r_target,
  output logic [3:0]    r_penalty
);
  localparam int IDX_W = HIST_W + 1;
  localparam int PHT_N = 1 << IDX_W;
  localparam int SB    = $clog2(BTB_SETS);
  localparam int TAG_W = AW - SB - 2;
  localparam int RUN_W = $clog2(RUN_LEN);
  localparam int WAY_W = (BTB_WAYS > 1) ? $clog2(BTB_WAYS) : 1;

  logic [1:0]       ctr   [PHT_N];
  logic [1:0]       bias  [PHT_N];
  logic [RUN_W-1:0] run   [PHT_N];
  logic             lastd [PHT_N];
  logic [HIST_W-1:0] hist [2];

  logic [BTB_WAYS-1:0] btb_v   [BTB_SETS];
  logic [BTB_WAYS-1:0] btb_mru [BTB_SETS];
  logic [TAG_W-1:0]    btb_tag [BTB_SETS][BTB_WAYS];
  logic [AW-1:0]       btb_tgt [BTB_SETS][BTB_WAYS];

  wire [IDX_W-1:0] f_idx = {f_pc[HIST_W+2], hist[f_tid] ^ f_pc[HIST_W+1:2]};
  wire [IDX_W-1:0] r_idx = {r_pc[HIST_W+2], hist[r_tid] ^ r_pc[HIST_W+1:2]};
  wire [SB-1:0]    f_set = f_pc[SB+1:2];
  wire [SB-1:0]    r_set = r_pc[SB+1:2];
  wire [TAG_W-1:0] f_tag = f_pc[AW-1:SB+2];
  wire [TAG_W-1:0] r_tag = r_pc[AW-1:SB+2];

  function automatic logic dir_of(input logic [1:0] b, input logic [1:0] c);
    return (b == 2'b01) ? 1'b1 : (b == 2'b10) ? 1'b0 : c[1];
  endfunction

  assign f_bias  = bias[f_idx];
  assign f_taken = dir_of(bias[f_idx], ctr[f_idx]);
  wire   r_pred  = dir_of(bias[r_idx], ctr[r_idx]);

  logic             r_hit, pick;
  logic [WAY_W-1:0] r_hway, r_vict;
  logic [AW-1:0]    r_old_tgt;

  always_comb begin
    f_tgt_valid = 1'b0;
    f_tgt       = '0;
    for (int w = 0; w < BTB_WAYS; w++)
      if (btb_v[f_set][w] && btb_tag[f_set][w] == f_tag) begin
        f_tgt_valid = 1'b1;
        f_tgt       = btb_tgt[f_set][w];
      end
  end

  always_comb begin
    r_hit     = 1'b0;
    r_hway    = '0;
    r_old_tgt = '0;
    r_vict    = '0;
    pick      = 1'b0;
    for (int w = 0; w < BTB_WAYS; w++)
      if (btb_v[r_set][w] && btb_tag[r_set][w] == r_tag) begin
        r_hit     = 1'b1;
        r_hway    = WAY_W'(w);
        r_old_tgt = btb_tgt[r_set][w];
      end
    for (int w = 0; w < BTB_WAYS; w++)
      if (!pick && !btb_v[r_set][w]) begin
        r_vict = WAY_W'(w);
        pick   = 1'b1;
      end
    for (int w = 0; w < BTB_WAYS; w++)
      if (!pick && !btb_mru[r_set][w]) begin
        r_vict = WAY_W'(w);
        pick   = 1'b1;
      end
  end

  wire [WAY_W-1:0]    r_wway  = r_hit ? r_hway : r_vict;
  wire [BTB_WAYS-1:0] w_oh    = BTB_WAYS'(1) << r_wway;
  wire [BTB_WAYS-1:0] mru_or  = btb_mru[r_set] | w_oh;
  wire [BTB_WAYS-1:0] mru_nxt = (&mru_or) ? w_oh : mru_or;

  always_comb begin
    r_penalty = 4'd0;
    if (r_valid) begin
      if (!r_uncond && r_pred != r_taken)
        r_penalty = 4'd13;
      else if (r_taken && (!r_hit || r_old_tgt != r_target))
        r_penalty = 4'd7;
    end
  end

  wire same_dir = (r_taken == lastd[r_idx]);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PHT_N; i++) begin
        ctr[i]   <= 2'b01;
        bias[i]  <= 2'b00;
        run[i]   <= '0;
        lastd[i] <= 1'b0;
      end
      hist[0] <= '0;
      hist[1] <= '0;
      for (int s = 0; s < BTB_SETS; s++) begin
        btb_v[s]   <= '0;
        btb_mru[s] <= '0;
      end
    end else if (r_valid) begin
      if (!r_uncond) begin
        hist[r_tid] <= {hist[r_tid][HIST_W-2:0], r_taken};
        if (r_taken && ctr[r_idx] != 2'b11)       ctr[r_idx] <= ctr[r_idx] + 2'b01;
        else if (!r_taken && ctr[r_idx] != 2'b00) ctr[r_idx] <= ctr[r_idx] - 2'b01;
        if (!same_dir) begin
          lastd[r_idx] <= r_taken;
          run[r_idx]   <= RUN_W'(1);
          bias[r_idx]  <= 2'b00;
        end else if (run[r_idx] == RUN_W'(RUN_LEN - 1)) begin
          bias[r_idx]  <= r_taken ? 2'b01 : 2'b10;
        end else begin
          run[r_idx]   <= run[r_idx] + RUN_W'(1);
        end
      end
      if (r_taken) begin
        btb_v[r_set][r_wway]   <= 1'b1;
        btb_tag[r_set][r_wway] <= r_tag;
        btb_tgt[r_set][r_wway] <= r_target;
        btb_mru[r_set]         <= mru_nxt;
      end
    end
  end
endmodule

// File: rtl/bpu_2t_chk.sv
module bpu_2t_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          f_taken,
  input logic [1:0]    f_bias,
  input logic          f_tgt_valid,
  input logic [AW-1:0] f_tgt,
  input logic [AW-1:0] f_pc,
  input logic          r_valid,
  input logic          r_uncond,
  input logic          r_taken,
  input logic [AW-1:0] r_pc,
  input logic [AW-1:0] r_target,
  input logic [3:0]    r_penalty
);
  assert_penalty_legal_R8: assert property (@(posedge clk) disable iff (rst)
    r_penalty == 4'd0 || r_penalty == 4'd7 || r_penalty == 4'd13);

  assert_idle_no_penalty_R8: assert property (@(posedge clk) disable iff (rst)
    !r_valid |-> r_penalty == 4'd0);

  assert_uncond_no_dir_miss_R4: assert property (@(posedge clk) disable iff (rst)
    (r_valid && r_uncond) |-> r_penalty != 4'd13);

  assert_bias_code_R5: assert property (@(posedge clk) disable iff (rst)
    f_bias != 2'b11);

  assert_bias_overrides_R5: assert property (@(posedge clk) disable iff (rst)
    (f_bias == 2'b01 |-> f_taken) and (f_bias == 2'b10 |-> !f_taken));

  assert_taken_fills_btb_R6: assert property (@(posedge clk) disable iff (rst)
    (r_valid && r_taken) |=> ((f_pc == $past(r_pc)) |-> (f_tgt_valid && f_tgt == $past(r_target))));
endmodule

bind bpu_2t bpu_2t_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .f_taken(f_taken), .f_bias(f_bias),
  .f_tgt_valid(f_tgt_valid), .f_tgt(f_tgt), .f_pc(f_pc),
  .r_valid(r_valid), .r_uncond(r_uncond), .r_taken(r_taken),
  .r_pc(r_pc), .r_target(r_target), .r_penalty(r_penalty)
);

// File: tb/bpu_2t_bench.sv
module bpu_2t_bench;
  localparam int AW = 16;
  logic clk = 1'b0, rst = 1'b1;
  logic f_tid = 1'b0, r_valid = 1'b0, r_tid = 1'b0, r_uncond = 1'b0, r_taken = 1'b0;
  logic [AW-1:0] f_pc = '0, r_pc = '0, r_target = '0;
  logic f_taken, f_tgt_valid;
  logic [1:0] f_bias;
  logic [AW-1:0] f_tgt;
  logic [3:0] r_penalty;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bpu_2t #(.HIST_W(4), .AW(AW), .BTB_SETS(4), .BTB_WAYS(4), .RUN_LEN(8)) u_bpu_2t (
    .clk(clk), .rst(rst), .f_tid(f_tid), .f_pc(f_pc), .f_taken(f_taken), .f_bias(f_bias),
    .f_tgt_valid(f_tgt_valid), .f_tgt(f_tgt), .r_valid(r_valid), .r_tid(r_tid), .r_pc(r_pc),
    .r_uncond(r_uncond), .r_taken(r_taken), .r_target(r_target), .r_penalty(r_penalty));

  // {tid, pc, uncond, taken, target, exp_taken, exp_tv, exp_tgt, exp_pen}
  localparam logic [56:0] VEC [9] = '{
    {1'b0, 16'h0040, 1'b0, 1'b1, 16'h0100, 1'b0, 1'b0, 16'h0000, 4'd13},
    {1'b1, 16'h0040, 1'b0, 1'b1, 16'h0100, 1'b1, 1'b1, 16'h0100, 4'd0},
    {1'b0, 16'h0040, 1'b0, 1'b0, 16'h0100, 1'b0, 1'b1, 16'h0100, 4'd0},
    {1'b0, 16'h0084, 1'b1, 1'b1, 16'h0200, 1'b0, 1'b0, 16'h0000, 4'd7},
    {1'b0, 16'h0084, 1'b1, 1'b1, 16'h0200, 1'b0, 1'b1, 16'h0200, 4'd0},
    {1'b0, 16'h0048, 1'b0, 1'b1, 16'h0300, 1'b1, 1'b0, 16'h0000, 4'd7},
    {1'b0, 16'h0048, 1'b0, 1'b1, 16'h0300, 1'b0, 1'b1, 16'h0300, 4'd13},
    {1'b0, 16'h0084, 1'b1, 1'b1, 16'h0280, 1'b0, 1'b1, 16'h0200, 4'd7},
    {1'b0, 16'h0084, 1'b1, 1'b1, 16'h0280, 1'b0, 1'b1, 16'h0280, 4'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; r_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic resolve(input logic tid, input logic [AW-1:0] pc, input logic unc,
                         input logic tk, input logic [AW-1:0] tgt);
    @(negedge clk);
    f_tid = tid; f_pc = pc; r_valid = 1'b1; r_tid = tid; r_pc = pc;
    r_uncond = unc; r_taken = tk; r_target = tgt;
    #1;
  endtask

  task automatic look(input logic tid, input logic [AW-1:0] pc);
    @(negedge clk);
    r_valid = 1'b0; f_tid = tid; f_pc = pc;
    #1;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    look(1'b0, 16'h0040);
    check("R1 taken", f_taken, 0);
    check("R1 bias", f_bias, 0);
    check("R1 tgt_valid", f_tgt_valid, 0);
    check("R8 idle penalty", r_penalty, 0);

    // R2 R3 R4 R6 R8 R9: vector walk, lookup sees pre-update state
    for (int i = 0; i < 9; i++) begin
      resolve(VEC[i][56], VEC[i][55:40], VEC[i][39], VEC[i][38], VEC[i][37:22]);
      check($sformatf("R2/R9 vec%0d taken", i), f_taken, VEC[i][21]);
      check($sformatf("R6 vec%0d tgt_valid", i), f_tgt_valid, VEC[i][20]);
      if (VEC[i][20]) check($sformatf("R6 vec%0d tgt", i), f_tgt, VEC[i][19:4]);
      check($sformatf("R8 vec%0d penalty", i), r_penalty, VEC[i][3:0]);
    end

    // R5 never-taken mark after 8 not-taken at one entry
    do_reset();
    for (int i = 0; i < 8; i++) begin
      resolve(1'b0, 16'h0040, 1'b0, 1'b0, 16'h0);
      check($sformatf("R5 nt step%0d bias", i), f_bias, 0);
    end
    look(1'b0, 16'h0040);
    check("R5 never mark", f_bias, 2'b10);
    check("R5 never predicts nt", f_taken, 0);
    resolve(1'b0, 16'h0040, 1'b0, 1'b1, 16'h0500);
    check("R8 biased miss penalty", r_penalty, 13);
    look(1'b1, 16'h0040);
    check("R5 mark cleared", f_bias, 0);
    check("R2 counter 01 after one taken", f_taken, 0);

    // R5 always-taken mark: thread 1 history saturates after 4 takens
    do_reset();
    for (int i = 0; i < 11; i++) resolve(1'b1, 16'h0040, 1'b0, 1'b1, 16'h0100);
    look(1'b1, 16'h0040);
    check("R5 seven outcomes no mark", f_bias, 0);
    resolve(1'b1, 16'h0040, 1'b0, 1'b1, 16'h0100);
    look(1'b1, 16'h0040);
    check("R5 always mark", f_bias, 2'b01);
    check("R5 always predicts taken", f_taken, 1);
    look(1'b0, 16'h0040);
    check("R3 thread0 history untouched", f_bias, 0);

    // R6 not-taken never allocates
    do_reset();
    resolve(1'b0, 16'h0104, 1'b0, 1'b0, 16'h0900);
    check("R8 correct nt penalty", r_penalty, 0);
    look(1'b0, 16'h0104);
    check("R6 no alloc on nt", f_tgt_valid, 0);

    // R7 replacement in set 0
    do_reset();
    for (int i = 1; i <= 4; i++) begin
      resolve(1'b0, AW'(i * 16), 1'b1, 1'b1, AW'(16'h1000 + i));
      check($sformatf("R8 fill%0d penalty", i), r_penalty, 7);
    end
    resolve(1'b0, 16'h0010, 1'b1, 1'b1, 16'h1001);
    check("R6 retouch hit penalty", r_penalty, 0);
    resolve(1'b0, 16'h0050, 1'b1, 1'b1, 16'h1005);
    check("R7 fifth alloc penalty", r_penalty, 7);
    look(1'b0, 16'h0010);
    check("R7 recent way kept", f_tgt_valid, 1);
    look(1'b0, 16'h0020);
    check("R7 way1 evicted", f_tgt_valid, 0);
    look(1'b0, 16'h0030);
    check("R7 way2 kept", f_tgt_valid, 1);
    look(1'b0, 16'h0050);
    check("R7 new entry", f_tgt_valid, 1);
    check("R7 new target", f_tgt, 16'h1005);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule